// File: doc/BRIEF.md
# Triggered Chirp Playback Generator

This block replays a stored chirp, one sample per clock, towards a 16-bit DAC each time a trigger pulse arrives. It holds sixteen sample sets in an internal bank, each with its own length register. A 4-bit select input names the set for the next pulse. The generator passes that input through a two-stage synchronizer and latches it when it accepts a trigger. It then waits a programmable number of cycles and streams the set from index 0 upwards, with a valid flag beside the data.

The generator does not interpret the samples. Up-chirps, down-chirps, linear laws and nonlinear laws all play back the same way. While it is idle, a simple load port fills the bank and the length registers. A trigger that arrives while a pulse is in progress is dropped and leaves a sticky overlap flag.

Top module: `chirp_player`

## Requirements
- R1: After reset, dac_valid, dac_data, busy and overlap are all 0, and every length register is 0.
- R2: When ld_en is high and busy is low, a clock edge acts on set ld_set. With ld_len = 0 it writes ld_data as the sample at index ld_addr. With ld_len = 1 it writes bits 6:0 of ld_data into that set's length register.
- R3: Let E be a clock edge that samples trig high after it was low at the previous edge, while busy is low, and let D be the delay value at E. The first sample (index 0) is on dac_data with dac_valid high after edge E+D+2. Later samples follow on consecutive edges in increasing index order.
- R4: A pulse emits exactly as many samples as the captured set's length register holds. After the last sample, dac_valid returns low. A length of 0 emits no sample.
- R5: The set played is the select input as seen through two flip-flop stages at edge E. The select must be steady for at least three edges before the trigger. A change after E does not affect the pulse in progress and takes effect at the next accepted trigger.
- R6: busy is high from just after edge E until the cycle in which the last sample is shown, inclusive. For length 0, busy is high through the cycle after edge E+D and low after edge E+D+1.
- R7: A rising trigger sampled while busy is high is ignored: the pulse in progress continues unchanged. It sets overlap, which stays high until reset.
- R8: Load port writes attempted while busy is high change neither samples nor lengths.
- R9: dac_data is 0 in every cycle in which dac_valid is low.
- R10: The delay input is captured at edge E. Later changes do not stretch or shorten the pulse in progress.
- R11: A length register value greater than 64 plays 64 samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Trigger, acted on at its rising edge |
| sel | input | 4 | Set to play on the next accepted trigger |
| delay | input | 16 | Extra cycles between trigger and first sample |
| ld_en | input | 1 | Load strobe |
| ld_len | input | 1 | 1: load length register, 0: load sample |
| ld_set | input | 4 | Set addressed by a load |
| ld_addr | input | 6 | Sample index addressed by a load |
| ld_data | input | 16 | Sample value, or length in bits 6:0 |
| dac_data | output | 16 | Sample word for the DAC |
| dac_valid | output | 1 | dac_data carries a sample |
| busy | output | 1 | A pulse is pending or playing |
| overlap | output | 1 | Sticky: a trigger was dropped while busy |

## Verification
The properties assume that trig is synchronous to clk and held low during reset. A rising edge is then a one-cycle change seen at a clock edge. The bench drives trig, sel, delay and the load port only on falling clock edges, holds the trigger low through reset, and settles the select three cycles before each trigger so that the synchronizer has passed it on. Retriggers, select and delay changes, and load attempts during a pulse are placed only in cycles where busy is known to be high.

// File: rtl/chirp_player.sv
module chirp_player #(
  parameter int SEL_W  = 4,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int DLY_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DLY_W-1:0]  delay,
  input  logic              ld_en,
  input  logic              ld_len,
  input  logic [SEL_W-1:0]  ld_set,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic [DATA_W-1:0] dac_data,
  output logic              dac_valid,
  output logic              busy,
  output logic              overlap
);
  localparam int NSETS = 1 << SEL_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LEN_W = ADDR_W + 1;

  typedef enum logic [1:0] {IDLE, WAIT, PLAY} st_t;

  st_t                st;
  logic [DATA_W-1:0]  mem [NSETS*DEPTH];
  logic [LEN_W-1:0]   len_r [NSETS];
  logic [SEL_W-1:0]   sel_m, sel_s, set_q;
  logic               trig_q;
  logic [DLY_W-1:0]   cnt;
  logic [ADDR_W-1:0]  idx;
  logic [LEN_W-1:0]   len_raw, len_eff;
  logic [ADDR_W-1:0]  last_idx;
  logic               rise, load_ok;

  assign rise     = trig & ~trig_q;
  assign busy     = (st != IDLE) | dac_valid;
  assign load_ok  = ld_en & ~busy;
  assign len_raw  = len_r[set_q];
  assign len_eff  = (len_raw > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : len_raw;
  assign last_idx = ADDR_W'(len_eff - 1'b1);

  always_ff @(posedge clk)
    if (load_ok && !ld_len) mem[{ld_set, ld_addr}] <= ld_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSETS; i++) len_r[i] <= '0;
    end else if (load_ok && ld_len) begin
      len_r[ld_set] <= ld_data[LEN_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_m  <= '0;
      sel_s  <= '0;
      trig_q <= 1'b0;
    end else begin
      sel_m  <= sel;
      sel_s  <= sel_m;
      trig_q <= trig;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      set_q     <= '0;
      cnt       <= '0;
      idx       <= '0;
      dac_data  <= '0;
      dac_valid <= 1'b0;
      overlap   <= 1'b0;
    end else begin
      if (rise && busy) overlap <= 1'b1;
      dac_valid <= (st == PLAY);
      dac_data  <= (st == PLAY) ? mem[{set_q, idx}] : '0;
      case (st)
        IDLE: if (rise && !busy) begin
          st    <= WAIT;
          set_q <= sel_s;
          cnt   <= delay;
        end
        WAIT: if (cnt == '0) begin
          st  <= (len_eff == '0) ? IDLE : PLAY;
          idx <= '0;
        end else begin
          cnt <= cnt - 1'b1;
        end
        PLAY: if (idx == last_idx) st <= IDLE;
              else                 idx <= idx + 1'b1;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chirp_player_chk.sv
module chirp_player_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig,
  input logic [DATA_W-1:0] dac_data,
  input logic              dac_valid,
  input logic              busy,
  input logic              overlap
);
  AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig) && !busy |=> busy && !dac_valid); // R6
  AST_DROP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig) && busy |=> overlap); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overlap |=> overlap); // R7
  AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_valid |-> dac_data == '0); // R9
  AST_FIRST_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_valid) |-> $past(busy)); // R3
endmodule

bind chirp_player chirp_player_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .dac_data(dac_data),
  .dac_valid(dac_valid), .busy(busy), .overlap(overlap)
);

// File: tb/test_chirp_player.sv
module test_chirp_player;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic [3:0]  sel = '0;
  logic [15:0] delay = '0;
  logic        ld_en = 1'b0;
  logic        ld_len = 1'b0;
  logic [3:0]  ld_set = '0;
  logic [5:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [15:0] dac_data;
  logic        dac_valid, busy, overlap;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chirp_player i_chirp_player (
    .clk(clk), .rst_n(rst_n), .trig(trig), .sel(sel), .delay(delay),
    .ld_en(ld_en), .ld_len(ld_len), .ld_set(ld_set), .ld_addr(ld_addr),
    .ld_data(ld_data), .dac_data(dac_data), .dac_valid(dac_valid),
    .busy(busy), .overlap(overlap)
  );

  function automatic logic [15:0] wv(int s, int i);
    return 16'(s * 4099 + i * 257 + 1);
  endfunction

  function automatic int len_raw(int s);
    if (s == 0)  return 0;
    if (s == 14) return 64;
    if (s == 15) return 100;
    return 3 * s + 1;
  endfunction

  function automatic int len_eff(int s);
    return (len_raw(s) > 64) ? 64 : len_raw(s);
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // one pulse: sel/delay settle, trigger, then cycle-by-cycle comparison
  task automatic run_pulse(int s, int d, bit chg, bit retrig, bit ldtry);
    int L, last, k0;
    logic exp_v;
    L = len_eff(s);
    last = (L == 0) ? d : d + 1 + L;
    sel = 4'(s);
    delay = 16'(d);
    repeat (3) @(negedge clk);
    trig = 1'b1;
    for (int k = 0; k <= last + 1; k++) begin
      @(negedge clk);
      k0 = k - d - 2;
      exp_v = (k >= d + 2) && (k <= d + 1 + L);
      chk("R3", {31'b0, dac_valid}, {31'b0, exp_v});
      if (exp_v) chk("R4", {16'b0, dac_data}, {16'b0, wv(s, k0)});
      else       chk("R9", {16'b0, dac_data}, 32'h0);
      chk("R6", {31'b0, busy}, {31'b0, k <= last});
      if (k == 0) trig = 1'b0;
      if (chg && k == 1) begin sel = 4'(s) ^ 4'hB; delay = 16'd7; end
      if (retrig && k == 2) trig = 1'b1;
      if (retrig && k == 3) trig = 1'b0;
      if (ldtry && k == 1) begin
        ld_en = 1'b1; ld_len = 1'b0; ld_set = 4'(s); ld_addr = '0; ld_data = 16'hDEAD;
      end
      if (ldtry && k == 2) begin
        ld_en = 1'b1; ld_len = 1'b1; ld_set = 4'(s); ld_data = 16'd2;
      end
      if (ldtry && k == 3) ld_en = 1'b0;
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1", {31'b0, dac_valid}, 32'h0);
    chk("R1", {16'b0, dac_data}, 32'h0);
    chk("R1", {31'b0, busy}, 32'h0);
    chk("R1", {31'b0, overlap}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_load;
    for (int s = 0; s < 16; s++)
      for (int i = 0; i < 64; i++) begin
        ld_en = 1'b1; ld_len = 1'b0; ld_set = 4'(s); ld_addr = 6'(i); ld_data = wv(s, i);
        @(negedge clk);
      end
    for (int s = 0; s < 16; s++) begin
      ld_en = 1'b1; ld_len = 1'b1; ld_set = 4'(s); ld_data = 16'(len_raw(s));
      @(negedge clk);
    end
    ld_en = 1'b0;
    chk("R2", {31'b0, busy}, 32'h0);
  endtask

  task automatic t_basic;
    run_pulse(3, 0, 0, 0, 0); // R2 R3 R4
    run_pulse(7, 5, 0, 0, 0); // R3 with delay
  endtask

  task automatic t_full_and_clamp;
    run_pulse(14, 2, 0, 0, 0); // R4 full depth
    run_pulse(15, 1, 0, 0, 0); // R11 clamp
  endtask

  task automatic t_zero_len;
    run_pulse(0, 3, 0, 0, 0); // R4 R6 zero length
  endtask

  task automatic t_sel_change;
    run_pulse(2, 1, 1, 0, 0); // R5 R10 changes mid-pulse ignored
    run_pulse(9, 7, 0, 0, 0); // R5 new select at next trigger
  endtask

  task automatic t_load_busy;
    run_pulse(5, 2, 0, 0, 1); // R8 writes during pulse
    run_pulse(5, 0, 0, 0, 0); // R8 sample and length unchanged
  endtask

  task automatic t_overlap;
    chk("R7", {31'b0, overlap}, 32'h0);
    run_pulse(6, 4, 0, 1, 0); // R7 pulse unchanged by retrigger
    chk("R7", {31'b0, overlap}, 32'h1);
    run_pulse(1, 0, 0, 0, 0);
    chk("R7", {31'b0, overlap}, 32'h1);
  endtask

  initial begin
    t_reset();
    t_load();
    t_basic();
    t_full_and_clamp();
    t_zero_len();
    t_sel_change();
    t_load_busy();
    t_overlap();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule